// File: doc/BRIEF.md
# X-Y Scatter Line-Buffer Display Stage

This stage sits in a raster display pipeline and overlays an X-Y scatter plot of two sampled signals on the passing video. The first channel sets the dot's column and the second sets its row. The stage keeps no frame store. It holds two one-row bitmaps, each as wide as the visible line. While one bitmap is shown on the current scan line, the other is built for the line below.

To build a bitmap, the stage looks at one recent sample pair on every clock of the line, including the blanking clocks. A sample reader outside the stage streams the pairs, newest first. Each pair is scaled to screen coordinates. If its row equals the next scan row, its column bit is set in the bitmap being built. At the last clock of every line the two bitmaps swap roles. Each shown bit is cleared as soon as it is read, so a bitmap starts empty when it is filled again.

The incoming pixel is passed on unchanged unless a plotted dot replaces it with a fixed colour. The scan position, both syncs and the blank flag are delayed by the same single register stage as the pixel, so they stay aligned with it.

Top module: `xy_plot_stage`

## Requirements
- R1: A sample pair maps to column `(x >>> XSHIFT) + H_VIS/2` and row `V_VIS/2 - 1 - (y >>> YSHIFT)`. Both shifts are arithmetic on the signed samples, so positive y moves up the screen.
- R2: A pair seen during scan line v marks its column only if its row equals v+1. The next row after the last line, V_TOT-1, is row 0. The mark shows as a dot on the following line.
- R3: Pairs are accepted on every one of the H_TOT clocks of a line, including the blanking clocks and the final clock.
- R4: A pair whose column falls outside 0..H_VIS-1 or whose row falls outside 0..V_VIS-1 marks nothing. This includes coordinates whose low bits alias an on-screen index.
- R5: The two bitmaps swap roles after the clock where `in_hcount` = H_TOT-1. The bitmap filled during a line is the one shown during the next line.
- R6: Every shown bit is cleared when it is read, whether or not drawing is enabled or blanked. A dot therefore appears on exactly one line.
- R7: `out_pixel` equals the input pixel of the previous clock, except at a marked column with drawing enabled and `in_blank` low, where it equals `DOT_COLOR`.
- R8: `out_hcount`, `out_vcount`, `out_hsync`, `out_vsync`, `out_blank` and `out_pixel` each lag their inputs by exactly one clock.
- R9: With `xy_en` low, pixels pass through unchanged and pairs seen in that line are not recorded.
- R10: While `rst_n` is low all outputs are zero, and after reset both bitmaps are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| xy_en | input | 1 | X-Y plot mode enable |
| in_hcount | input | $clog2(H_TOT) | Incoming scan column |
| in_vcount | input | $clog2(V_TOT) | Incoming scan row |
| in_hsync | input | 1 | Incoming horizontal sync |
| in_vsync | input | 1 | Incoming vertical sync |
| in_blank | input | 1 | Incoming blank flag |
| in_pixel | input | PIX_W | Pixel from the previous stage |
| pair_vld | input | 1 | A sample pair is present this clock |
| pair_x | input | SMP_W | Signed channel-1 sample (column) |
| pair_y | input | SMP_W | Signed channel-2 sample (row) |
| out_hcount | output | $clog2(H_TOT) | Delayed scan column |
| out_vcount | output | $clog2(V_TOT) | Delayed scan row |
| out_hsync | output | 1 | Delayed horizontal sync |
| out_vsync | output | 1 | Delayed vertical sync |
| out_blank | output | 1 | Delayed blank flag |
| out_pixel | output | PIX_W | Pass-through or dot-coloured pixel |

## Verification
A wrong bitmap-select bit shows one line later: dots appear on the line they were captured in, or two lines late, and not on the line after capture. A missed clear shows two lines after the dot was drawn, as a ghost at the same column on a line where no pair was fed. A wrong row comparison or range check shows on the very next line as a missing or extra dot, which is why the tests include aliasing coordinates, the final blanking clock and the wrap from the last row to row 0. A broken delay shows at once on the control outputs.

// File: rtl/xyp_pkg.sv
package xyp_pkg;
  typedef struct packed {
    logic hsync;
    logic vsync;
    logic blank;
  } xyp_ctl_t;
endpackage

// File: rtl/xyp_rst_sync.sv
module xyp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign srst_n = stg_q[1];
endmodule

// File: rtl/xyp_coord_map.sv
module xyp_coord_map #(
  parameter int SMP_W  = 12,
  parameter int H_VIS  = 1280,
  parameter int V_VIS  = 1024,
  parameter int XSHIFT = 1,
  parameter int YSHIFT = 1,
  parameter int CW     = 11,
  parameter int RW     = 11
) (
  input  logic signed [SMP_W-1:0] smp_x,
  input  logic signed [SMP_W-1:0] smp_y,
  output logic        [CW-1:0]    col,
  output logic        [RW-1:0]    row,
  output logic                    on_screen
);
  logic signed [31:0] xe, ye, cpos, rpos;

  always_comb begin
    xe   = 32'(smp_x);
    ye   = 32'(smp_y);
    cpos = (xe >>> XSHIFT) + 32'(H_VIS / 2);
    rpos = 32'(V_VIS / 2 - 1) - (ye >>> YSHIFT);
    on_screen = (cpos >= 0) && (cpos < 32'(H_VIS)) &&
                (rpos >= 0) && (rpos < 32'(V_VIS));
    col = cpos[CW-1:0];
    row = rpos[RW-1:0];
  end
endmodule

// File: rtl/xyp_rowbufs.sv
module xyp_rowbufs #(
  parameter int COLS = 1280,
  parameter int IW   = 11
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          swap,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_col,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_col,
  output logic          rd_bit
);
  logic                  sel_q, sel_d;
  logic [1:0][COLS-1:0]  bank_q, bank_d;
  logic [COLS-1:0]       wr_oh, rd_oh;

  always_comb begin
    for (int i = 0; i < COLS; i++) begin
      wr_oh[i] = wr_en && (wr_col == IW'(i));
      rd_oh[i] = rd_en && (rd_col == IW'(i));
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_bank
    assign bank_d[g] = (sel_q == 1'(g)) ? (bank_q[g] | wr_oh)
                                        : (bank_q[g] & ~rd_oh);
  end

  assign sel_d  = sel_q ^ swap;
  assign rd_bit = |(bank_q[~sel_q] & rd_oh);

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      sel_q  <= 1'b0;
      bank_q <= '0;
    end else begin
      sel_q  <= sel_d;
      bank_q <= bank_d;
    end
  end
endmodule

// File: rtl/xy_plot_stage.sv
module xy_plot_stage
  import xyp_pkg::*;
#(
  parameter int H_VIS  = 1280,
  parameter int H_TOT  = 1688,
  parameter int V_VIS  = 1024,
  parameter int V_TOT  = 1066,
  parameter int SMP_W  = 12,
  parameter int XSHIFT = 1,
  parameter int YSHIFT = 1,
  parameter int PIX_W  = 12,
  parameter logic [PIX_W-1:0] DOT_COLOR = {PIX_W{1'b1}},
  localparam int HC_W  = $clog2(H_TOT),
  localparam int VC_W  = $clog2(V_TOT)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    xy_en,
  input  logic [HC_W-1:0]         in_hcount,
  input  logic [VC_W-1:0]         in_vcount,
  input  logic                    in_hsync,
  input  logic                    in_vsync,
  input  logic                    in_blank,
  input  logic [PIX_W-1:0]        in_pixel,
  input  logic                    pair_vld,
  input  logic signed [SMP_W-1:0] pair_x,
  input  logic signed [SMP_W-1:0] pair_y,
  output logic [HC_W-1:0]         out_hcount,
  output logic [VC_W-1:0]         out_vcount,
  output logic                    out_hsync,
  output logic                    out_vsync,
  output logic                    out_blank,
  output logic [PIX_W-1:0]        out_pixel
);
  logic            srst_n;
  logic [HC_W-1:0] map_col;
  logic [VC_W-1:0] map_row, tgt_row;
  logic            map_on, wr_en, rd_en, swap, rd_bit;
  logic [PIX_W-1:0] pix_d, pix_q;
  logic [HC_W-1:0]  hc_q;
  logic [VC_W-1:0]  vc_q;
  xyp_ctl_t         ctl_d, ctl_q;

  xyp_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  xyp_coord_map #(
    .SMP_W(SMP_W), .H_VIS(H_VIS), .V_VIS(V_VIS),
    .XSHIFT(XSHIFT), .YSHIFT(YSHIFT), .CW(HC_W), .RW(VC_W)
  ) u_map (
    .smp_x(pair_x), .smp_y(pair_y),
    .col(map_col), .row(map_row), .on_screen(map_on)
  );

  xyp_rowbufs #(.COLS(H_VIS), .IW(HC_W)) u_bufs (
    .clk(clk), .srst_n(srst_n), .swap(swap),
    .wr_en(wr_en), .wr_col(map_col),
    .rd_en(rd_en), .rd_col(in_hcount), .rd_bit(rd_bit)
  );

  always_comb begin
    tgt_row = (in_vcount == VC_W'(V_TOT - 1)) ? '0 : in_vcount + 1'b1;
    wr_en   = xy_en && pair_vld && map_on && (map_row == tgt_row);
    rd_en   = in_hcount < HC_W'(H_VIS);
    swap    = in_hcount == HC_W'(H_TOT - 1);
    pix_d   = (xy_en && !in_blank && rd_bit) ? DOT_COLOR : in_pixel;
    ctl_d   = '{hsync: in_hsync, vsync: in_vsync, blank: in_blank};
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      hc_q  <= '0;
      vc_q  <= '0;
      ctl_q <= '0;
      pix_q <= '0;
    end else begin
      hc_q  <= in_hcount;
      vc_q  <= in_vcount;
      ctl_q <= ctl_d;
      pix_q <= pix_d;
    end
  end

  assign out_hcount = hc_q;
  assign out_vcount = vc_q;
  assign out_hsync  = ctl_q.hsync;
  assign out_vsync  = ctl_q.vsync;
  assign out_blank  = ctl_q.blank;
  assign out_pixel  = pix_q;
endmodule

// File: rtl/xyp_chk.sv
module xyp_chk #(
  parameter int HC_W  = 11,
  parameter int VC_W  = 11,
  parameter int PIX_W = 12,
  parameter logic [PIX_W-1:0] DOT = '1
) (
  input logic             clk,
  input logic             srst_n,
  input logic             xy_en,
  input logic [HC_W-1:0]  in_hcount,
  input logic [VC_W-1:0]  in_vcount,
  input logic             in_hsync,
  input logic             in_vsync,
  input logic             in_blank,
  input logic [PIX_W-1:0] in_pixel,
  input logic [HC_W-1:0]  out_hcount,
  input logic [VC_W-1:0]  out_vcount,
  input logic             out_hsync,
  input logic             out_vsync,
  input logic             out_blank,
  input logic [PIX_W-1:0] out_pixel
);
  logic past_ok;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R8
  delay_align_chk: assert property (@(posedge clk) disable iff (!srst_n)
    past_ok |-> (out_hcount == $past(in_hcount)) && (out_vcount == $past(in_vcount)) &&
                (out_hsync == $past(in_hsync)) && (out_vsync == $past(in_vsync)) &&
                (out_blank == $past(in_blank)));

  // R7
  blank_pass_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (past_ok && $past(in_blank)) |-> (out_pixel == $past(in_pixel)));

  // R9
  disabled_pass_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (past_ok && !$past(xy_en)) |-> (out_pixel == $past(in_pixel)));

  // R7
  pix_source_chk: assert property (@(posedge clk) disable iff (!srst_n)
    past_ok |-> ((out_pixel == $past(in_pixel)) || (out_pixel == DOT)));
endmodule

bind xy_plot_stage xyp_chk #(
  .HC_W(HC_W), .VC_W(VC_W), .PIX_W(PIX_W), .DOT(DOT_COLOR)
) u_chk (
  .clk(clk), .srst_n(srst_n), .xy_en(xy_en),
  .in_hcount(in_hcount), .in_vcount(in_vcount),
  .in_hsync(in_hsync), .in_vsync(in_vsync), .in_blank(in_blank),
  .in_pixel(in_pixel),
  .out_hcount(out_hcount), .out_vcount(out_vcount),
  .out_hsync(out_hsync), .out_vsync(out_vsync), .out_blank(out_blank),
  .out_pixel(out_pixel)
);

// File: tb/xy_plot_stage_tb.sv
module xy_plot_stage_tb_top;
  localparam logic [7:0] DOT = 8'hE5;

  logic clk, rst_n, xy_en, in_hsync, in_vsync, in_blank, pair_vld;
  logic [4:0] in_hcount, out_hcount;
  logic [3:0] in_vcount, out_vcount;
  logic [7:0] in_pixel, out_pixel;
  logic signed [7:0] pair_x, pair_y;
  logic out_hsync, out_vsync, out_blank;

  int nchk = 0, nerr = 0;
  bit done = 0;
  bit pv_a [20];
  logic signed [7:0] px_a [20];
  logic signed [7:0] py_a [20];

  xy_plot_stage #(
    .H_VIS(16), .H_TOT(20), .V_VIS(8), .V_TOT(10), .SMP_W(8),
    .XSHIFT(0), .YSHIFT(0), .PIX_W(8), .DOT_COLOR(DOT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .xy_en(xy_en),
    .in_hcount(in_hcount), .in_vcount(in_vcount),
    .in_hsync(in_hsync), .in_vsync(in_vsync), .in_blank(in_blank),
    .in_pixel(in_pixel), .pair_vld(pair_vld), .pair_x(pair_x), .pair_y(pair_y),
    .out_hcount(out_hcount), .out_vcount(out_vcount),
    .out_hsync(out_hsync), .out_vsync(out_vsync), .out_blank(out_blank),
    .out_pixel(out_pixel)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_pairs();
    for (int h = 0; h < 20; h++) begin
      pv_a[h] = 1'b0; px_a[h] = '0; py_a[h] = '0;
    end
  endtask

  task automatic put_pair(input int h, input int x, input int y);
    pv_a[h] = 1'b1; px_a[h] = 8'(x); py_a[h] = 8'(y);
  endtask

  // Column = x + 8, row = 3 - y (R1).
  task automatic run_line(input int v, input bit en, input bit fblank,
                          input logic [19:0] expm, input string tag);
    logic [7:0] expp;
    for (int h = 0; h < 20; h++) begin
      @(negedge clk);
      in_hcount = 5'(h);
      in_vcount = 4'(v);
      in_hsync  = (h >= 17);
      in_vsync  = (v == 9);
      in_blank  = fblank || (h >= 16) || (v >= 8);
      in_pixel  = 8'((h * 7 + v) & 127);
      xy_en     = en;
      pair_vld  = pv_a[h];
      pair_x    = px_a[h];
      pair_y    = py_a[h];
      @(posedge clk);
      #5;
      expp = expm[h] ? DOT : in_pixel;
      chk(out_pixel == expp, tag, out_pixel, expp);
      chk({out_hcount, out_vcount, out_hsync, out_vsync, out_blank} ==
          {in_hcount, in_vcount, in_hsync, in_vsync, in_blank}, "R8",
          {out_hcount, out_vcount, out_hsync, out_vsync, out_blank},
          {in_hcount, in_vcount, in_hsync, in_vsync, in_blank});
    end
    clear_pairs();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; xy_en = 1'b1; in_hcount = 5'd7; in_vcount = 4'd3;
    in_hsync = 1'b1; in_vsync = 1'b1; in_blank = 1'b1; in_pixel = 8'h55;
    pair_vld = 1'b0; pair_x = '0; pair_y = '0;
    clear_pairs();
    repeat (3) @(posedge clk);
    #5;
    chk(out_pixel == 8'h0, "R10", out_pixel, 0);
    chk({out_hcount, out_vcount, out_hsync, out_vsync, out_blank} == '0, "R10",
        {out_hcount, out_vcount, out_hsync, out_vsync, out_blank}, 0);
    @(negedge clk);
    rst_n = 1'b1; in_hcount = '0; in_vcount = '0; in_pixel = '0;
    repeat (4) @(posedge clk);
    run_line(0, 1, 0, 20'h0, "R10 empty");
  endtask

  task automatic t_basic();
    put_pair(0, -3, 0);
    put_pair(4, 7, 0);
    put_pair(6, -8, 0);
    put_pair(9, 1, 1);
    put_pair(19, 2, 0);
    run_line(2, 1, 0, 20'h0, "R5 fill line");
    run_line(3, 1, 0, 20'h08421, "R1 R2 R3 plot");
  endtask

  task automatic t_clear();
    run_line(4, 1, 0, 20'h0, "R5");
    run_line(5, 1, 0, 20'h0, "R6 cleared");
  endtask

  task automatic t_offscreen();
    put_pair(1, 24, -4);
    put_pair(2, -40, -4);
    put_pair(3, 8, -4);
    put_pair(5, 0, -4);
    run_line(6, 1, 0, 20'h0, "R4 fill");
    run_line(7, 1, 0, 20'h00100, "R4 offscreen");
  endtask

  task automatic t_disabled();
    put_pair(4, 0, 1);
    run_line(1, 0, 0, 20'h0, "R9 pass");
    run_line(2, 1, 0, 20'h0, "R9 not recorded");
    put_pair(4, -5, 1);
    run_line(1, 1, 0, 20'h0, "R9 fill");
    run_line(2, 0, 0, 20'h0, "R9 display off");
    run_line(3, 1, 0, 20'h0, "R6");
    run_line(4, 1, 0, 20'h0, "R6 cleared while off");
  endtask

  task automatic t_blank();
    put_pair(7, 4, 0);
    run_line(2, 1, 0, 20'h0, "R7 fill");
    run_line(3, 1, 1, 20'h0, "R7 blanked");
    run_line(4, 1, 0, 20'h0, "R6");
    run_line(5, 1, 0, 20'h0, "R6 cleared while blank");
  endtask

  task automatic t_wrap();
    put_pair(11, -2, 3);
    run_line(9, 1, 0, 20'h0, "R7 vblank");
    run_line(0, 1, 0, 20'h00040, "R2 wrap");
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_clear();
    t_offscreen();
    t_disabled();
    t_blank();
    t_wrap();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule